// File: doc/BRIEF.md
# Event Counter Bank with Global Enable and Overflow Status

This block holds a bank of event counters that share one global enable word and one overflow status word. Each counter has its own event-select register. That register picks one of the event inputs and holds a local enable bit and an interrupt-enable bit. A counter advances by one on each cycle in which its selected event input is high, but only while both its local enable and its bit in the global enable word are set. Writing zero to the global enable word halts the whole bank in one cycle. Writing the implemented mask starts every counter that is already programmed.

When a counter wraps from all-ones to zero, its bit in the status word is set at the same clock edge. The status word cannot be written. Software acknowledges overflows by writing ones to a separate clear address. The interrupt request is the OR of every status bit whose counter has its interrupt enable set. Access goes through a simple single-cycle register port: writes take effect at the clock edge and reads are combinational.

Address map, as word addresses on `addr`:
- Counter i is at address i.
- The event select for counter i is at address 8+i.
- The global enable word is at 16.
- The status word is at 17.
- The status-clear word is at 18.

Event-select layout:
- Bits [2:0] give the event input index.
- Bit 8 is the local enable.
- Bit 9 is the interrupt enable.

Top module: `pcu_top`

## Requirements
- R1: Reset clears the global enable word, the status word, every counter, every event select and `irq`. Each of these then reads as zero.
- R2: A counter increments by exactly one per cycle only when its selected event input is high, its local enable (select bit 8) is set and its global enable bit is set. If any one of these is missing, it holds its value.
- R3: Writing address 16 loads the global enable word. Writing 0 stops all counters and writing the mask 0x3F starts all of them. Bits 6 and above are not stored and read as zero.
- R4: Writes to the status address 17 have no effect on the status word.
- R5: Writing address 18 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. Address 18 reads as zero.
- R6: A counter that steps from all-ones wraps to zero and sets its status bit at that same clock edge.
- R7: `irq` is high exactly when some status bit is set whose counter has its interrupt enable (select bit 9) set. It stays high until software clears those bits.
- R8: When a counter write and an increment of the same counter fall in the same cycle, the written value is stored.
- R9: When an overflow and a clear of the same status bit fall in the same cycle, the bit ends set.
- R10: Only the event input named by select bits [2:0] advances a counter. Pulses on other inputs are ignored. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | 48 | Write data |
| rdata | output | 48 | Read data for `addr`, combinational |
| evt_in | input | 8 | Event pulse inputs, one per event source |
| irq | output | 1 | Overflow interrupt request |

## Verification
A corrupted enable or select bit shows up on the next read of the affected counter. The counter then holds a value, or advances, against the count of pulses the bench applied in the cycle before. A status bit that is wrongly set, lost or cleared changes `rdata` at address 17, and changes `irq` when its interrupt enable is on, from the clock edge right after the fault. The bench therefore reads the status word and samples `irq` immediately after every overflow, clear and reset it drives. Wrap and same-cycle conflicts are forced by preloading counters to all-ones through the write port. This keeps every fault within a few cycles of the check that reveals it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    // word addresses of the register port
    localparam int CNT_BASE  = 0;
    localparam int SEL_BASE  = 8;
    localparam int CTL_ADDR  = 16;
    localparam int STAT_ADDR = 17;
    localparam int CLR_ADDR  = 18;
    // event-select field positions
    localparam int EN_BIT    = 8;
    localparam int IE_BIT    = 9;
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int DATA_W  = 48
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_we,
    input  logic               sel_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               glob_en,
    output logic [CNT_W-1:0]   count,
    output logic [DATA_W-1:0]  sel_word,
    output logic               int_en,
    output logic               inc,
    output logic               ovf
);
    import pcu_pkg::*;
    localparam int SEL_W = $clog2(NUM_EVT);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] evt_idx_q;
    logic             loc_en_q;
    logic             ie_q;

    // step only when both enables agree and the chosen event fires
    assign inc = loc_en_q & glob_en & evt_in[evt_idx_q];
    // a write in the same cycle suppresses the step, so no wrap either
    assign ovf = inc & ~cnt_we & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            evt_idx_q <= '0;
            loc_en_q  <= 1'b0;
            ie_q      <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt_q <= wdata[CNT_W-1:0];
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (sel_we) begin
                evt_idx_q <= wdata[SEL_W-1:0];
                loc_en_q  <= wdata[EN_BIT];
                ie_q      <= wdata[IE_BIT];
            end
        end
    end

    always_comb begin
        sel_word              = '0;
        sel_word[SEL_W-1:0]   = evt_idx_q;
        sel_word[EN_BIT]      = loc_en_q;
        sel_word[IE_BIT]      = ie_q;
    end

    assign count  = cnt_q;
    assign int_en = ie_q;
endmodule

// File: rtl/pcu_status.sv
module pcu_status #(
    parameter int NUM_CNT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] ovf,
    input  logic [NUM_CNT-1:0] clr,
    input  logic [NUM_CNT-1:0] int_en,
    output logic [NUM_CNT-1:0] status,
    output logic               irq
);
    logic [NUM_CNT-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            // a new overflow outranks an acknowledge of the same bit
            status_q <= (status_q & ~clr) | ovf;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & int_en);
endmodule

// File: rtl/pcu_top.sv
module pcu_top #(
    parameter int NUM_CNT = 6,
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int DATA_W  = 48,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    import pcu_pkg::*;

    logic [NUM_CNT-1:0] glob_en_q;
    logic [NUM_CNT-1:0] status_q;
    logic [NUM_CNT-1:0] ovf_vec;
    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] ie_vec;
    logic [NUM_CNT-1:0] clr_vec;
    logic [CNT_W-1:0]   count   [NUM_CNT];
    logic [DATA_W-1:0]  sel_rd  [NUM_CNT];

    logic ctl_we;
    logic clr_we;
    assign ctl_we  = wr_en && (addr == ADDR_W'(CTL_ADDR));
    assign clr_we  = wr_en && (addr == ADDR_W'(CLR_ADDR));
    assign clr_vec = clr_we ? wdata[NUM_CNT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_q <= '0;
        end else if (ctl_we) begin
            glob_en_q <= wdata[NUM_CNT-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pcu_counter #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT),
            .DATA_W  (DATA_W)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .cnt_we   (wr_en && (addr == ADDR_W'(CNT_BASE + g))),
            .sel_we   (wr_en && (addr == ADDR_W'(SEL_BASE + g))),
            .wdata    (wdata),
            .evt_in   (evt_in),
            .glob_en  (glob_en_q[g]),
            .count    (count[g]),
            .sel_word (sel_rd[g]),
            .int_en   (ie_vec[g]),
            .inc      (inc_vec[g]),
            .ovf      (ovf_vec[g])
        );
    end

    pcu_status #(.NUM_CNT(NUM_CNT)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .ovf    (ovf_vec),
        .clr    (clr_vec),
        .int_en (ie_vec),
        .status (status_q),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTL_ADDR)) begin
            rdata[NUM_CNT-1:0] = glob_en_q;
        end else if (addr == ADDR_W'(STAT_ADDR)) begin
            rdata[NUM_CNT-1:0] = status_q;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(CNT_BASE + i)) rdata = DATA_W'(count[i]);
            if (addr == ADDR_W'(SEL_BASE + i)) rdata = sel_rd[i];
        end
    end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int NUM_CNT = 6,
    parameter int DATA_W  = 48,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               irq,
    input logic [NUM_CNT-1:0] glob_en_q,
    input logic [NUM_CNT-1:0] status_q,
    input logic [NUM_CNT-1:0] ovf_vec,
    input logic [NUM_CNT-1:0] clr_vec,
    input logic [NUM_CNT-1:0] inc_vec
);
    import pcu_pkg::*;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (status_q == '0 && glob_en_q == '0 && !irq));

    assert_gated_count_R2: assert property (@(posedge clk) disable iff (rst)
        (inc_vec & ~glob_en_q) == '0);

    assert_ctl_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(CTL_ADDR)) |=> glob_en_q == $past(wdata[NUM_CNT-1:0]));

    assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (|ovf_vec) |=> ((status_q & $past(ovf_vec)) == $past(ovf_vec)));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_q != '0));
endmodule

bind pcu_top pcu_checker #(
    .NUM_CNT (NUM_CNT),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .glob_en_q (glob_en_q),
    .status_q  (status_q),
    .ovf_vec   (ovf_vec),
    .clr_vec   (clr_vec),
    .inc_vec   (inc_vec)
);

// File: tb/sim_pcu_top.sv
module sim_pcu_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 48;
    localparam logic [DW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [7:0]    evt_in = '0;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq(irq)
    );

    // vector: [53] 1=read-compare 0=write, [52:48] address, [47:0] data
    localparam int NV = 13;
    localparam logic [53:0] VEC [NV] = '{
        {1'b1, 5'd16, 48'h0},            // R1 global enable after reset
        {1'b1, 5'd17, 48'h0},            // R1 status after reset
        {1'b1, 5'd3,  48'h0},            // R1 counter after reset
        {1'b0, 5'd16, 48'hFFFF_FFFF_FFFF},
        {1'b1, 5'd16, 48'h3F},           // R3 only implemented bits kept
        {1'b0, 5'd17, 48'h3F},
        {1'b1, 5'd17, 48'h0},            // R4 status ignores writes
        {1'b0, 5'd16, 48'h0},
        {1'b1, 5'd16, 48'h0},            // R3 zero stops all
        {1'b1, 5'd31, 48'h0},            // R10 unmapped reads zero
        {1'b1, 5'd18, 48'h0},            // R5 clear address reads zero
        {1'b0, 5'd1,  48'h1234},
        {1'b1, 5'd1,  48'h1234}          // R8 counter write path
    };
    localparam string TAG [NV] = '{"R1","R1","R1","R3","R3","R4","R4",
                                   "R3","R3","R10","R5","R8","R8"};

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse(input logic [7:0] e, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_in = e;
        end
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual irq=%b expected=0", irq);
        end

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][53]) rd_check(TAG[v], VEC[v][52:48], VEC[v][47:0]);
            else            wr(VEC[v][52:48], VEC[v][47:0]);
        end

        // R2 / R10: counter0 follows event 2 only
        wr(5'd0, 48'd0);
        wr(5'd8, 48'h102);
        wr(5'd16, 48'h01);
        pulse(8'h04, 3);
        pulse(8'h02, 2);
        rd_check("R2", 5'd0, 48'd3);
        rd_check("R10", 5'd8, 48'h102);
        // R3: global off halts counting
        wr(5'd16, 48'h00);
        pulse(8'h04, 4);
        rd_check("R3", 5'd0, 48'd3);
        // R2: local enable clear, global on, counter1 holds
        wr(5'd1, 48'd7);
        wr(5'd9, 48'h002);
        wr(5'd16, 48'h3F);
        pulse(8'h04, 2);
        rd_check("R2", 5'd1, 48'd7);
        rd_check("R2", 5'd0, 48'd5);

        // R6 / R7: wrap with interrupt enabled
        wr(5'd8, 48'h302);
        wr(5'd0, ONES);
        pulse(8'h04, 1);
        rd_check("R6", 5'd0, 48'd0);
        rd_check("R6", 5'd17, 48'h01);
        check("R7", {47'd0, irq}, 48'd1);
        pulse(8'h04, 1);
        check("R7", {47'd0, irq}, 48'd1);
        wr(5'd18, 48'h3E);
        rd_check("R5", 5'd17, 48'h01);
        wr(5'd18, 48'h01);
        rd_check("R5", 5'd17, 48'h00);
        check("R7", {47'd0, irq}, 48'd0);

        // R7: overflow on counter1 without interrupt enable
        wr(5'd9, 48'h102);
        wr(5'd1, ONES);
        pulse(8'h04, 1);
        rd_check("R7", 5'd17, 48'h02);
        check("R7", {47'd0, irq}, 48'd0);
        wr(5'd18, 48'h02);

        // R9: overflow and clear of bit 0 in the same cycle
        wr(5'd0, ONES);
        @(negedge clk);
        evt_in = 8'h04; wr_en = 1'b1; addr = 5'd18; wdata = 48'h01;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0;
        rd_check("R9", 5'd17, 48'h01);
        wr(5'd18, 48'h01);

        // R8: write and increment in the same cycle
        @(negedge clk);
        evt_in = 8'h04; wr_en = 1'b1; addr = 5'd0; wdata = 48'd5;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0;
        rd_check("R8", 5'd0, 48'd5);

        // R1: reset during activity
        wr(5'd0, ONES);
        pulse(8'h04, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check("R1", 5'd16, 48'h0);
        rd_check("R1", 5'd17, 48'h0);
        rd_check("R1", 5'd8, 48'h0);
        rd_check("R1", 5'd0, 48'h0);
        check("R1", {47'd0, irq}, 48'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule